// File: doc/BRIEF.md
# Input Pin Glitch Qualifier

This block cleans up one asynchronous digital input before the rest of the chip uses it. The raw pin is first brought into the system clock domain through a chain of flops. A free-running prescaler then produces a single-cycle sample strobe every n system clocks. The most recent samples are kept in a short history. The filtered output takes a new level only when the last m samples all show that level. Software-facing logic supplies an 8-bit period code and a one-bit sample-count select as static configuration.

The prescaler is never realigned to input edges. A pulse therefore meets a strobe at an arbitrary phase. Any pulse of n*m cycles always passes. Pulses of n*(m-1) cycles or fewer never pass. In between, the outcome depends on phase: at the shortest passing width, n*m-(n-1) cycles, exactly one of the n possible phases lets the pulse through. Changing the period code restarts the prescaler, which gives the strobe a known phase.

Top module: `pin_qual_filter`

## Requirements
- R1: A synchronous active-high reset drives `qual_out` to 0 and clears the sample history to all zeros.
- R2: The strobe period n is 1 cycle when `period_sel` is 0, and 2*`period_sel` cycles otherwise, so n ranges over 1..510.
- R3: `count_sel`=0 requires 3 matching consecutive samples and `count_sel`=1 requires 6 before the output may change.
- R4: An input level held for n*m system clocks changes `qual_out` for every phase of the strobe.
- R5: An input level held for only n*(m-1) system clocks never changes `qual_out`, whatever its phase.
- R6: A pulse of n*m-(n-1) cycles changes `qual_out` for exactly one of the n phases. For n=510 and m=6, 2551 cycles can pass and 2550 cannot.
- R7: `qual_out` changes only on a sample strobe, and only to the newest sampled value. Any disagreement among the last m samples leaves `qual_out` unchanged.
- R8: The pin passes two synchronizer flops before it is sampled. With n=1 and m=3, a rising pin ahead of clock edge 0 makes `qual_out` high at edge 4, and not earlier.
- R9: A change of `period_sel` restarts the prescaler and takes no sample in that cycle. The first strobe comes n cycles later. For n>=2, a pulse of n*(m-1)+1 cycles that rises d cycles after the write passes exactly when d = n-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 1 | Asynchronous pin level |
| period_sel | input | 8 | Period code k: n=1 when k=0, else n=2k |
| count_sel | input | 1 | Sample count select: 0 selects 3 samples, 1 selects 6 |
| qual_out | output | 1 | Qualified pin level |

## Verification
Two events can fall in the same cycle: a write of a new period code and the prescaler reaching its terminal count. When both occur, the restart must win and no sample may be taken. The bench provokes this on purpose. It rewrites the period code twice in a row and then sweeps the pulse start across every phase. Each sweep must show exactly one passing phase, at d = n-2, which only holds if the colliding strobe was suppressed and the count restarted from zero. A checker also measures every strobe interval against the period code.

// File: rtl/pqf_pkg.sv
package pqf_pkg;
  localparam int HIST_MAX = 6;
  localparam int NEED_LO  = 3;
  localparam int NEED_HI  = 6;

  // period code to strobe interval in clocks
  function automatic int period_cycles(input int code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

  function automatic int need_samples(input logic sel);
    return sel ? NEED_HI : NEED_LO;
  endfunction

  // mask covering the newest cnt history bits
  function automatic logic [HIST_MAX-1:0] low_mask(input int cnt);
    logic [HIST_MAX-1:0] mk;
    mk = '0;
    for (int i = 0; i < HIST_MAX; i++) mk[i] = (i < cnt);
    return mk;
  endfunction
endpackage

// File: rtl/pqf_sync.sv
module pqf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pqf_prescaler.sv
module pqf_prescaler #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period_sel,
  output logic                strobe,
  output logic                restart
);
  import pqf_pkg::*;
  localparam int CNT_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] code_q;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    last_cnt;

  assign last_cnt = CNT_W'(period_cycles(int'(period_sel)) - 1);
  assign restart  = (period_sel != code_q);
  assign strobe   = !restart && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      cnt    <= '0;
    end else begin
      code_q <= period_sel;
      if (restart || strobe) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pqf_window.sv
module pqf_window (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          strobe,
  input  logic                          samp,
  input  logic                          count_sel,
  output logic                          qual,
  output logic [pqf_pkg::HIST_MAX-1:0] hist
);
  import pqf_pkg::*;

  logic [HIST_MAX-1:0] nxt;
  logic [HIST_MAX-1:0] mask;
  logic                all_hi;
  logic                all_lo;
  logic                flip;

  assign nxt    = {hist[HIST_MAX-2:0], samp};
  assign mask   = low_mask(need_samples(count_sel));
  assign all_hi = ((nxt & mask) == mask);
  assign all_lo = ((nxt & mask) == '0);
  assign flip   = strobe && ((all_hi && !qual) || (all_lo && qual));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      qual <= 1'b0;
    end else begin
      if (strobe) hist <= nxt;
      if (flip)   qual <= ~qual;
    end
  end
endmodule

// File: rtl/pin_qual_filter.sv
module pin_qual_filter #(
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pin_raw,
  input  logic [PERIOD_W-1:0] period_sel,
  input  logic                count_sel,
  output logic                qual_out
);
  import pqf_pkg::*;

  logic                samp_sync;
  logic                smp_stb;
  logic                per_chg;
  logic [HIST_MAX-1:0] hist_w;

  pqf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(samp_sync)
  );

  pqf_prescaler #(.PERIOD_W(PERIOD_W)) u_pre (
    .clk(clk), .rst(rst), .period_sel(period_sel),
    .strobe(smp_stb), .restart(per_chg)
  );

  pqf_window u_win (
    .clk(clk), .rst(rst), .strobe(smp_stb), .samp(samp_sync),
    .count_sel(count_sel), .qual(qual_out), .hist(hist_w)
  );
endmodule

// File: rtl/pqf_checker.sv
module pqf_checker #(
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [PERIOD_W-1:0] period_sel,
  input logic                count_sel,
  input logic                smp_stb,
  input logic                per_chg,
  input logic                samp_sync,
  input logic                qual_out
);
  import pqf_pkg::*;

  logic [PERIOD_W+1:0] gap;
  logic [2:0]          run;
  logic                last_s;

  always_ff @(posedge clk) begin
    if (rst || smp_stb || per_chg) gap <= 1;
    else                           gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 3'd7;
      last_s <= 1'b0;
    end else if (smp_stb) begin
      last_s <= samp_sync;
      if (samp_sync == last_s) run <= (run == 3'd7) ? run : run + 1'b1;
      else                     run <= 3'd1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (qual_out == 1'b0));

  assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> (int'(gap) == period_cycles(int'(period_sel))));

  assert_run_length_R3: assert property (@(posedge clk) disable iff (rst)
    (qual_out != $past(qual_out)) |-> (int'(run) >= need_samples($past(count_sel))));

  assert_hold_off_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(qual_out));

  assert_flip_to_sample_R7: assert property (@(posedge clk) disable iff (rst)
    (qual_out != $past(qual_out)) |-> (qual_out == $past(samp_sync)));

  assert_restart_wins_R9: assert property (@(posedge clk) disable iff (rst)
    per_chg |-> !smp_stb);
endmodule

bind pin_qual_filter pqf_checker #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .period_sel(period_sel), .count_sel(count_sel),
  .smp_stb(smp_stb), .per_chg(per_chg), .samp_sync(samp_sync),
  .qual_out(qual_out)
);

// File: tb/sim_pin_qual_filter.sv
module sim_pin_qual_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_raw = 1'b0;
  logic [7:0] period_sel = 8'd0;
  logic       count_sel = 1'b0;
  logic       qual_out;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pin_qual_filter u0 (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .period_sel(period_sel),
    .count_sel(count_sel), .qual_out(qual_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int bn(input int k);
    if (k == 0) return 1;
    return k + k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // restart prescaler by two code writes; the last one lands ahead of edge 0
  task automatic restart_to(input int k);
    period_sel = (k == 0) ? 8'd1 : 8'd0;
    @(negedge clk);
    period_sel = 8'(k);
  endtask

  task automatic trial(input int k, input bit ms, input int d, input int w,
                       output bit got);
    int n, m;
    n = bn(k);
    m = ms ? 6 : 3;
    count_sel = ms;
    pin_raw = 1'b0;
    got = 1'b0;
    restart_to(k);
    for (int i = 0; i < d; i++) begin @(negedge clk); got |= qual_out; end
    pin_raw = 1'b1;
    for (int i = 0; i < w; i++) begin @(negedge clk); got |= qual_out; end
    pin_raw = 1'b0;
    for (int i = 0; i < n * m + n + 6; i++) begin @(negedge clk); got |= qual_out; end
    if (qual_out !== 1'b0) check("R4 settle low", int'(qual_out), 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(qual_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", int'(qual_out), 0);
  endtask

  task automatic t_latency;
    count_sel = 1'b0;
    restart_to(0);
    repeat (8) @(negedge clk);
    pin_raw = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 not before edge 4", int'(qual_out), 0);
    @(negedge clk);
    check("R8 high at edge 4", int'(qual_out), 1);
    pin_raw = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 back low", int'(qual_out), 0);
  endtask

  task automatic t_mismatch;
    int seen;
    count_sel = 1'b0;
    restart_to(0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      pin_raw = (i % 3 != 2);
      @(negedge clk);
      seen |= int'(qual_out);
    end
    check("R7 two-of-three stays low", seen, 0);
    count_sel = 1'b1;
    seen = 0;
    for (int i = 0; i < 36; i++) begin
      pin_raw = (i % 6 != 5);
      @(negedge clk);
      seen |= int'(qual_out);
    end
    check("R3 five-of-six stays low with 6 needed", seen, 0);
    pin_raw = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 steady high qualifies", int'(qual_out), 1);
    count_sel = 1'b0;
    seen = 1;
    for (int i = 0; i < 30; i++) begin
      pin_raw = (i % 3 == 2);
      @(negedge clk);
      seen &= int'(qual_out);
    end
    check("R7 broken low run keeps high", seen, 1);
    pin_raw = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 steady low releases", int'(qual_out), 0);
  endtask

  task automatic t_sweep(input int k, input bit ms);
    int n, m, cnt_full, cnt_short, cnt_edge, where;
    bit got;
    n = bn(k);
    m = ms ? 6 : 3;
    cnt_full = 0; cnt_short = 0; cnt_edge = 0; where = -1;
    for (int d = 0; d < n; d++) begin
      trial(k, ms, d, n * m, got);
      cnt_full += int'(got);
      trial(k, ms, d, n * (m - 1), got);
      cnt_short += int'(got);
      trial(k, ms, d, n * m - (n - 1), got);
      if (got) begin cnt_edge++; where = d; end
    end
    check($sformatf("R4 n=%0d m=%0d full width all phases", n, m), cnt_full, n);
    check($sformatf("R5 n=%0d m=%0d short width no phase", n, m), cnt_short, 0);
    check($sformatf("R6 n=%0d m=%0d edge width one phase", n, m), cnt_edge, 1);
    check($sformatf("R9 n=%0d m=%0d passing phase", n, m), where, (n == 1) ? 0 : n - 2);
  endtask

  task automatic t_widest;
    bit got;
    trial(255, 1'b1, 508, 2551, got);
    check("R6 n=510 2551 at phase 508", int'(got), 1);
    trial(255, 1'b1, 507, 2551, got);
    check("R9 n=510 2551 at phase 507", int'(got), 0);
    trial(255, 1'b1, 509, 2551, got);
    check("R9 n=510 2551 at phase 509", int'(got), 0);
    trial(255, 1'b1, 508, 2550, got);
    check("R5 n=510 2550 at best phase", int'(got), 0);
    trial(255, 1'b1, 3, 3060, got);
    check("R4 n=510 3060 cycles", int'(got), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_mismatch();
    t_sweep(0, 1'b0);
    t_sweep(0, 1'b1);
    t_sweep(2, 1'b1);
    t_sweep(3, 1'b0);
    t_sweep(5, 1'b1);
    t_widest();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule